// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog Timer

This block is an 8-bit watchdog counter that counts down on a slow tick. The tick comes from a prescaler that divides the system clock; by default it divides by 131072, which gives about 763 Hz from 100 MHz. Software controls the block with single control writes. Each write carries a start value, a start/stop command and a 7-bit key. A write takes effect only when its key is the bitwise inverse of the last key that was accepted. A stray or runaway write therefore cannot restart or stop the timer.

Expiry has two stages. When the count steps down to one, the block emits a one-cycle non-maskable interrupt pulse, which gives the handler one tick period to act. When the count steps down to zero, the block raises a system reset request. That request stays high until the block's own reset clears it. Restarting the timer is the same operation as starting it.

Top module: `keyed_watchdog`

## Requirements
- R1: After `rst`, `running` is 0, `count` is 0, `nmi_pulse` and `sys_rst` are 0, and the stored key is 0, so the first key that can be accepted is 7'h7F.
- R2: A write is a cycle with `wr_en` high. `wr_start` selects start (1) or stop (0), `wr_cnt` is the 8-bit start value and `wr_key` is the 7-bit key. The write is accepted only when `wr_key` equals the stored key XOR 7'h7F. An accepted key becomes the new stored key.
- R3: A write whose key does not match changes nothing: `count`, `running` and the stored key all keep their values.
- R4: An accepted start loads `wr_cnt` into `count` and sets `running`, on the clock edge that captures the write. This applies whether the timer was stopped or running. The start also clears the prescaler.
- R5: An accepted stop clears `running`. While stopped, `count` holds its value.
- R6: While running, `count` decreases by one once every PRESCALE clock cycles. The first decrement comes PRESCALE cycles after the edge that accepted the start.
- R7: When `count` steps from 2 to 1, `nmi_pulse` is high for exactly one cycle, aligned with `count` becoming 1.
- R8: When `count` steps from 1 to 0, `sys_rst` goes high in the same cycle and `running` is cleared. `sys_rst` stays high until `rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control write strobe, one cycle per write |
| wr_cnt | input | 8 | Start value carried by the write |
| wr_start | input | 1 | Command: 1 start/restart, 0 stop |
| wr_key | input | 7 | Key carried by the write |
| nmi_pulse | output | 1 | One-cycle early-warning interrupt |
| sys_rst | output | 1 | Sticky system reset request |
| running | output | 1 | Timer is counting |
| count | output | 8 | Current counter value |

## Verification
A stored key that is wrong stays hidden until the next write. That write is then rejected or accepted against the model, and `count` and `running` show the result on the very next cycle. The vector table alternates correct and wrong keys so that any drift appears within one write. A prescaler that is not cleared or that divides by the wrong amount moves the first decrement away from exactly PRESCALE cycles. The bench samples `count` at PRESCALE-1 and at PRESCALE to catch this. Errors in the expiry stages show up as an interrupt pulse that is missing, shifted or too wide around the 2-to-1 step, or as a reset request that drops before `rst`.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int CNT_W = 8;
    localparam int KEY_W = 7;

    typedef enum logic {
        WD_CMD_HALT = 1'b0,
        WD_CMD_RUN  = 1'b1
    } wd_cmd_e;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        wd_cmd_e          cmd;
        logic [KEY_W-1:0] key;
    } wd_ctrl_t;

    typedef struct packed {
        logic start;
        logic stop;
    } wd_act_t;

    function automatic logic [KEY_W-1:0] expected_key(input logic [KEY_W-1:0] prev);
        return prev ^ {KEY_W{1'b1}};
    endfunction
endpackage

// File: rtl/wdt_key_gate.sv
module wdt_key_gate
    import wdt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  wd_ctrl_t ctrl,
    output wd_act_t  act
);
    logic [KEY_W-1:0] key_q;
    logic             match;

    assign match     = wr_en && (ctrl.key == expected_key(key_q));
    assign act.start = match && (ctrl.cmd == WD_CMD_RUN);
    assign act.stop  = match && (ctrl.cmd == WD_CMD_HALT);

    always_ff @(posedge clk) begin
        if (rst)        key_q <= '0;
        else if (match) key_q <= ctrl.key;
    end

    // Each accepted write flips every bit of the stored key
    p_key_flip_r2: assert property (@(posedge clk) disable iff (rst)
        (act.start || act.stop) |=> (key_q == ~$past(key_q)));
    // A cycle with no accepted write leaves the key alone
    p_key_keep_r3: assert property (@(posedge clk) disable iff (rst)
        !(act.start || act.stop) |=> $stable(key_q));
endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
    parameter int DIV = 131072
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic clr,
    output logic tick
);
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] div_q;

    assign tick = run && (div_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr || !run) div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                    div_q <= div_q + PW'(1);
    end

    // Ticks are separated by the full division ratio, never back to back
    p_tick_gap_r6: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  wd_act_t          act,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             running,
    output logic             nmi,
    output logic             bite
);
    logic dec;

    assign dec = running && tick && (count != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            count   <= '0;
            running <= 1'b0;
            nmi     <= 1'b0;
            bite    <= 1'b0;
        end else begin
            nmi <= 1'b0;
            if (act.start) begin
                count   <= load_val;
                running <= 1'b1;
            end else if (act.stop) begin
                running <= 1'b0;
            end else if (dec) begin
                count <= count - CNT_W'(1);
                nmi   <= (count == CNT_W'(2));
                if (count == CNT_W'(1)) begin
                    bite    <= 1'b1;
                    running <= 1'b0;
                end
            end
        end
    end

    p_hold_stopped_r5: assert property (@(posedge clk) disable iff (rst)
        (!running && !act.start) |=> $stable(count));
    p_single_step_r6: assert property (@(posedge clk) disable iff (rst)
        (running && !act.start) |=> (count == $past(count) || count == $past(count) - CNT_W'(1)));
    p_nmi_one_cycle_r7: assert property (@(posedge clk) disable iff (rst)
        nmi |=> !nmi);
    p_nmi_at_one_r7: assert property (@(posedge clk) disable iff (rst)
        nmi |-> (count == CNT_W'(1)));
    p_bite_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        bite |=> bite);
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import wdt_pkg::*;
#(
    parameter int PRESCALE = 131072
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_cnt,
    input  logic             wr_start,
    input  logic [KEY_W-1:0] wr_key,
    output logic             nmi_pulse,
    output logic             sys_rst,
    output logic             running,
    output logic [CNT_W-1:0] count
);
    wd_ctrl_t ctrl;
    wd_act_t  act;
    logic     tick;

    assign ctrl.cnt = wr_cnt;
    assign ctrl.cmd = wd_cmd_e'(wr_start);
    assign ctrl.key = wr_key;

    wdt_key_gate u_key (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .ctrl  (ctrl),
        .act   (act)
    );

    wdt_prescale #(.DIV(PRESCALE)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (running),
        .clr  (act.start),
        .tick (tick)
    );

    wdt_core u_core (
        .clk      (clk),
        .rst      (rst),
        .act      (act),
        .load_val (ctrl.cnt),
        .tick     (tick),
        .count    (count),
        .running  (running),
        .nmi      (nmi_pulse),
        .bite     (sys_rst)
    );

    // A bite always ends the counting phase
    p_bite_stops_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_rst) |-> !running);
endmodule

// File: tb/test_keyed_watchdog.sv
module test_keyed_watchdog;
    localparam int P = 16;

    typedef struct packed {
        logic [7:0] cnt;
        logic       start;
        logic [6:0] key;
        logic       exp_run;
        logic [7:0] exp_cnt;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{8'd200, 1'b1, 7'h00, 1'b0, 8'd0},
        '{8'd200, 1'b1, 7'h7F, 1'b1, 8'd200},
        '{8'd0,   1'b0, 7'h7F, 1'b1, 8'd200},
        '{8'd50,  1'b1, 7'h55, 1'b1, 8'd200},
        '{8'd0,   1'b0, 7'h00, 1'b0, 8'd200},
        '{8'd90,  1'b1, 7'h00, 1'b0, 8'd200},
        '{8'd90,  1'b1, 7'h7F, 1'b1, 8'd90},
        '{8'd33,  1'b1, 7'h7F, 1'b1, 8'd90},
        '{8'd33,  1'b1, 7'h00, 1'b1, 8'd33},
        '{8'd0,   1'b0, 7'h7F, 1'b0, 8'd33}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_cnt = '0;
    logic       wr_start = 1'b0;
    logic [6:0] wr_key = '0;
    logic       nmi_pulse, sys_rst, running;
    logic [7:0] count;

    int n_chk = 0;
    int n_bad = 0;
    logic [6:0] mkey = 7'h00;

    always #10 clk = ~clk;

    keyed_watchdog #(.PRESCALE(P)) i_keyed_watchdog (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_cnt(wr_cnt),
        .wr_start(wr_start), .wr_key(wr_key), .nmi_pulse(nmi_pulse),
        .sys_rst(sys_rst), .running(running), .count(count)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] c, input logic s, input logic [6:0] k);
        @(negedge clk);
        wr_cnt = c; wr_start = s; wr_key = k; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog timeout actual 0 expected 1");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 running", running, 0);
        chk("R1 count", count, 0);
        chk("R1 nmi", nmi_pulse, 0);
        chk("R1 sys_rst", sys_rst, 0);

        // Vector table: R2 key gating, R3 ignore, R4 start/restart, R5 stop
        foreach (VECS[i]) begin
            wr(VECS[i].cnt, VECS[i].start, VECS[i].key);
            chk($sformatf("R2/R3/R4/R5 vec%0d running", i), running, VECS[i].exp_run);
            chk($sformatf("R2/R3/R4/R5 vec%0d count", i), count, VECS[i].exp_cnt);
        end
        mkey = 7'h7F;

        // R5: stopped counter holds its value
        repeat (40) @(negedge clk);
        chk("R5 hold while stopped", count, 33);

        // R4/R6: restart clears the prescaler, first step PRESCALE after it
        mkey = ~mkey;
        wr(8'd10, 1'b1, mkey);
        repeat (10) @(negedge clk);
        chk("R4 no early step", count, 10);
        mkey = ~mkey;
        wr(8'd10, 1'b1, mkey);
        for (int k = 1; k <= P; k++) begin
            @(negedge clk);
            if (k == P - 1) chk("R6 before first step", count, 10);
            if (k == P)     chk("R6 first step", count, 9);
        end

        // R7/R8: expiry from a start value of 3
        mkey = ~mkey;
        wr(8'd3, 1'b1, mkey);
        for (int k = 1; k <= 3 * P; k++) begin
            @(negedge clk);
            if (k == 2 * P - 1) chk("R7 nmi before", nmi_pulse, 0);
            if (k == 2 * P) begin
                chk("R7 nmi pulse", nmi_pulse, 1);
                chk("R7 count at nmi", count, 1);
            end
            if (k == 2 * P + 1) chk("R7 nmi one cycle", nmi_pulse, 0);
            if (k == 3 * P - 1) chk("R8 no early reset", sys_rst, 0);
            if (k == 3 * P) begin
                chk("R8 reset raised", sys_rst, 1);
                chk("R8 count zero", count, 0);
                chk("R8 running cleared", running, 0);
            end
        end
        repeat (20) @(negedge clk);
        chk("R8 reset held", sys_rst, 1);
        chk("R8 no second nmi", nmi_pulse, 0);

        // R1: block reset clears everything and the key returns to 0
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset clears sys_rst", sys_rst, 0);
        chk("R1 reset count", count, 0);
        wr(8'd5, 1'b1, 7'h7F);
        chk("R1 first key 7F accepted", count, 5);
        chk("R1 running after first key", running, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule